// File: doc/BRIEF.md
# PHY Register Handshake Access Engine

This engine reaches the 16-bit registers of a PHY that has no memory-mapped path of its own. It talks to the PHY through two words. The engine drives a 20-bit control word, and the PHY returns a 17-bit status word. The low 16 bits of the control word carry either a register address or write data. Four strobe bits above them tell the PHY what to do with that field. The PHY answers every strobe change by moving a single acknowledge bit in the status word. The status word also carries read data.

On the user side, a request consists of a direction, a 16-bit address and 16-bit write data. The engine accepts a request only while it is idle. It then runs a chain of four-phase handshakes. In each one it raises a strobe, waits for the acknowledge to go high, drops the strobe and waits for the acknowledge to go low. Every acknowledge wait is bounded. A wait that never sees the expected level ends the access with an error. At the end of every access the engine returns a one-cycle completion pulse, together with read data for a read.

The acknowledge bit crosses into the engine's clock domain through a two-flop synchronizer before it is compared. The PHY itself is not part of the block.

Top module: `phy_hs_engine`

## Requirements
- R1: The control word places the data/address field in bits 15:0. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is high in any cycle.
- R2: The status word returns read data in bits 15:0 and the acknowledge in bit 16.
- R3: Every access starts with an address phase. The address is placed in bits 15:0, then capture-address is raised until the acknowledge is high. Capture-address is then dropped, with the address kept in the field, until the acknowledge is low.
- R4: A write follows the address phase with a capture-data handshake (write data held in bits 15:0) and then a write-strobe handshake. The control word is all zero once the access completes.
- R5: A read follows the address phase by raising the read strobe alone, with bits 15:0 zero. When the acknowledge is high, bits 15:0 of the status word are captured. The control word is then cleared and the engine waits for the acknowledge to go low. The captured value appears on `rdata` at completion and holds until the next read captures.
- R6: Each acknowledge wait makes at most POLL_LIMIT checks, POLL_GAP cycles apart, with the first check in the cycle the wait begins. If the expected level is not seen, the access aborts: `err` is set and the control word returns to zero. When the capture-address handshake is never answered, `done` rises exactly 2 + (POLL_LIMIT-1)*POLL_GAP clock edges after the accepting edge.
- R7: A wait for the acknowledge to fall is bounded in the same way, so an acknowledge stuck high also aborts with `err`.
- R8: `req_ready` is high only while idle, and the control word is zero while idle. A request presented while busy is ignored: it produces no completion and touches no PHY register.
- R9: `done` is a one-cycle pulse per accepted request. `err` is valid in the same cycle, and is 0 when every handshake completed.
- R10: The acknowledge passes through exactly two synchronizer flops. An acknowledge edge at the PHY becomes visible to the comparison two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Engine idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | 16 | Read data from the last completed read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The bench builds the engine with POLL_GAP = 4 and POLL_LIMIT = 3. These values make an acknowledge timeout a matter of a few cycles rather than ten microseconds of polling. A PHY model with an adjustable response delay then reaches the exact edge of the window. A delay of six cycles is caught on the last check, and seven cycles misses it. This pins down both the check spacing and the two-flop synchronizer latency. The same short window lets the bench time a fully silent PHY to the exact edge, and lets it abort on an acknowledge that never falls.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  localparam int FIELD_W  = 16;
  localparam int CTRL_W   = 20;
  localparam int STAT_W   = 17;
  localparam int BIT_CAPA = 16;
  localparam int BIT_CAPD = 17;
  localparam int BIT_WR   = 18;
  localparam int BIT_RD   = 19;
  localparam int BIT_ACK  = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SET,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA_SET,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WR_STB,
    ST_WR_REL,
    ST_RD_STB,
    ST_RD_REL
  } step_t;

endpackage

// File: rtl/phy_hs_rst_sync.sv
module phy_hs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_sync = rs_q[1];
endmodule

// File: rtl/phy_hs_sync.sv
module phy_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/phy_hs_poll.sv
module phy_hs_poll #(
  parameter int GAP   = 50,
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic exp_lvl,
  input  logic ack,
  output logic hit,
  output logic expire
);
  localparam int GAP_W = $clog2(GAP + 1);
  localparam int CHK_W = $clog2(LIMIT + 1);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [CHK_W-1:0] chk_q, chk_d;
  logic at_check, match;

  always_comb begin
    at_check = (gap_q == '0);
    match    = (ack == exp_lvl);
    hit      = en && at_check && match;
    expire   = en && at_check && !match && (chk_q == CHK_W'(LIMIT - 1));
    gap_d    = gap_q;
    chk_d    = chk_q;
    if (!en || hit || expire) begin
      gap_d = '0;
      chk_d = '0;
    end else if (at_check) begin
      gap_d = GAP_W'(GAP - 1);
      chk_d = chk_q + 1'b1;
    end else begin
      gap_d = gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      chk_q <= '0;
    end else begin
      gap_q <= gap_d;
      chk_q <= chk_d;
    end
  end

  // R6: the check counter never passes the allowed number of checks
  a_r6_check_bound: assert property (@(posedge clk) disable iff (!rst_n)
    chk_q < CHK_W'(LIMIT));

  // R6: a wait cannot both succeed and time out
  a_r6_hit_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && expire));
endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
  import phy_hs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [FIELD_W-1:0] req_addr,
  input  logic [FIELD_W-1:0] req_wdata,
  input  logic [FIELD_W-1:0] stat_data,
  input  logic               hit,
  input  logic               expire,
  output logic               poll_en,
  output logic               poll_exp,
  output logic               req_ready,
  output logic               done,
  output logic               err,
  output logic [FIELD_W-1:0] rdata,
  output logic [CTRL_W-1:0]  ctrl_word
);
  step_t              step_q, step_d;
  logic [FIELD_W-1:0] addr_q, addr_d;
  logic [FIELD_W-1:0] wdat_q, wdat_d;
  logic               wr_q, wr_d;
  logic [FIELD_W-1:0] rdat_q, rdat_d;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               accept, cap_rd;

  function automatic logic [CTRL_W-1:0] ctrl_for(step_t s, logic [FIELD_W-1:0] a,
                                                 logic [FIELD_W-1:0] d);
    logic [CTRL_W-1:0] w;
    w = '0;
    case (s)
      ST_ADDR_SET, ST_ADDR_REL:           w[FIELD_W-1:0] = a;
      ST_ADDR_CAP: begin                  w[FIELD_W-1:0] = a; w[BIT_CAPA] = 1'b1; end
      ST_DATA_SET, ST_DATA_REL, ST_WR_REL: w[FIELD_W-1:0] = d;
      ST_DATA_CAP: begin                  w[FIELD_W-1:0] = d; w[BIT_CAPD] = 1'b1; end
      ST_WR_STB:                          w[BIT_WR] = 1'b1;
      ST_RD_STB:                          w[BIT_RD] = 1'b1;
      default:                            w = '0;
    endcase
    return w;
  endfunction

  always_comb begin
    poll_en  = step_q inside {ST_ADDR_CAP, ST_ADDR_REL, ST_DATA_CAP, ST_DATA_REL,
                              ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL};
    poll_exp = step_q inside {ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB};
    accept   = (step_q == ST_IDLE) && req_valid;
    cap_rd   = (step_q == ST_RD_STB) && hit;
  end

  always_comb begin
    step_d = step_q;
    addr_d = accept ? req_addr  : addr_q;
    wdat_d = accept ? req_wdata : wdat_q;
    wr_d   = accept ? req_write : wr_q;
    rdat_d = cap_rd ? stat_data : rdat_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (step_q)
      ST_IDLE:     if (accept) step_d = ST_ADDR_SET;
      ST_ADDR_SET: step_d = ST_ADDR_CAP;
      ST_ADDR_CAP: if (hit) step_d = ST_ADDR_REL;
      ST_ADDR_REL: if (hit) step_d = wr_q ? ST_DATA_SET : ST_RD_STB;
      ST_DATA_SET: step_d = ST_DATA_CAP;
      ST_DATA_CAP: if (hit) step_d = ST_DATA_REL;
      ST_DATA_REL: if (hit) step_d = ST_WR_STB;
      ST_WR_STB:   if (hit) step_d = ST_WR_REL;
      ST_WR_REL:   if (hit) begin step_d = ST_IDLE; done_d = 1'b1; end
      ST_RD_STB:   if (hit) step_d = ST_RD_REL;
      ST_RD_REL:   if (hit) begin step_d = ST_IDLE; done_d = 1'b1; end
      default:     step_d = ST_IDLE;
    endcase
    if (expire) begin
      step_d = ST_IDLE;
      done_d = 1'b1;
      err_d  = 1'b1;
    end
    ctrl_d = ctrl_for(step_d, addr_d, wdat_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      ctrl_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      ctrl_q <= ctrl_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      wr_q   <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdat_q <= '0;
    else if (cap_rd) rdat_q <= rdat_d;
  end

  assign req_ready = (step_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rdat_q;
  assign ctrl_word = ctrl_q;

  // R1: strobes are mutually exclusive
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_q[BIT_RD:BIT_CAPA]));

  // R5: the read strobe travels with an empty data field
  a_r5_read_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[BIT_RD] |-> (ctrl_q[FIELD_W-1:0] == '0));

  // R5: read data holds outside the read-strobe step
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != ST_RD_STB) |=> $stable(rdat_q));

  // R8: an idle engine drives a quiet control word
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ctrl_q == '0));

  // R9: completion is a single-cycle pulse, and error only comes with it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);

  // R4: a completed access leaves the control word cleared
  a_r4_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ctrl_q == '0));
endmodule

// File: rtl/phy_hs_engine.sv
module phy_hs_engine
  import phy_hs_pkg::*;
#(
  parameter int POLL_GAP    = 50,
  parameter int POLL_LIMIT  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [FIELD_W-1:0] req_addr,
  input  logic [FIELD_W-1:0] req_wdata,
  output logic               req_ready,
  output logic               done,
  output logic               err,
  output logic [FIELD_W-1:0] rdata,
  output logic [CTRL_W-1:0]  phy_ctrl,
  input  logic [STAT_W-1:0]  phy_stat
);
  logic rst_n_s;
  logic ack_s;
  logic poll_en, poll_exp, hit, expire;

  phy_hs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  phy_hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (phy_stat[BIT_ACK]),
    .q     (ack_s)
  );

  phy_hs_poll #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (poll_en),
    .exp_lvl (poll_exp),
    .ack     (ack_s),
    .hit     (hit),
    .expire  (expire)
  );

  phy_hs_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .stat_data (phy_stat[FIELD_W-1:0]),
    .hit       (hit),
    .expire    (expire),
    .poll_en   (poll_en),
    .poll_exp  (poll_exp),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .ctrl_word (phy_ctrl)
  );
endmodule

// File: tb/tb_phy_hs_engine.sv
module tb_phy_hs_engine;
  localparam int GAP = 4;
  localparam int LIM = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready, done, err;
  logic [15:0] rdata;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #10 clk = ~clk;

  phy_hs_engine #(.POLL_GAP(GAP), .POLL_LIMIT(LIM), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .err(err), .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  // PHY model: answers strobes after dly edges; can be muted or stuck high
  int          dly = 1;
  bit          mute = 0, stuck = 0;
  logic        ack;
  int          cnt;
  logic [15:0] mdata, maddr, mlat;
  logic [15:0] mem [256];
  logic        want;

  assign phy_stat = {ack, mdata};

  always @(posedge clk) begin
    want = |phy_ctrl[19:16];
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; mdata <= '0; maddr <= '0; mlat <= '0;
    end else if (want != ack && !(want && mute) && !(!want && stuck)) begin
      if (cnt >= dly - 1) begin
        ack <= want;
        cnt <= 0;
        if (want) begin
          if (phy_ctrl[16]) maddr <= phy_ctrl[15:0];
          if (phy_ctrl[17]) mlat  <= phy_ctrl[15:0];
          if (phy_ctrl[18]) mem[maddr[7:0]] <= mlat;
          if (phy_ctrl[19]) mdata <= mem[maddr[7:0]];
        end
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  // strobe log
  logic [3:0] stb_log[$];
  logic [3:0] prev_stb = 4'h0;
  always @(negedge clk) begin
    if (phy_ctrl[19:16] != prev_stb) begin
      if (phy_ctrl[19:16] != 4'h0) stb_log.push_back(phy_ctrl[19:16]);
      prev_stb = phy_ctrl[19:16];
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    bit          is_rd;
    logic [15:0] data;
    bit          err;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R8", "unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "err flag (R9)", {31'd0, err}, {31'd0, e.err});
        if (e.is_rd && !e.err) chk(e.tag, "read data (R5)", {16'd0, rdata}, {16'd0, e.data});
      end
    end
  end

  task automatic start_access(bit wr, logic [15:0] a, logic [15:0] d,
                              bit exp_err, logic [15:0] exp_rd, string tag);
    exp_t e;
    e.is_rd = !wr; e.data = exp_rd; e.err = exp_err; e.tag = tag;
    exp_q.push_back(e);
    while (!req_ready) @(negedge clk);
    stb_log.delete();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 1;
    while (!done) begin @(negedge clk); cycles++; end
    @(negedge clk);
    chk("R9", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic access(bit wr, logic [15:0] a, logic [15:0] d,
                        bit exp_err, logic [15:0] exp_rd, string tag);
    int c;
    start_access(wr, a, d, exp_err, exp_rd, tag);
    wait_done(c);
    chk("R4", "ctrl zero after access", {12'd0, phy_ctrl}, 32'd0);
  endtask

  function automatic logic [15:0] log_code();
    logic [15:0] v;
    v = '0;
    foreach (stb_log[i]) v = {v[11:0], stb_log[i]};
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R8", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "ctrl after reset", {12'd0, phy_ctrl}, 32'd0);
    chk("R9", "done after reset", {31'd0, done}, 32'd0);
    chk("R9", "err after reset", {31'd0, err}, 32'd0);

    // R3 R4: write sequence capA(1), capD(2), WR(4)
    access(1, 16'h0012, 16'hBEEF, 0, 16'h0, "R4");
    chk("R3", "write strobe order", {16'd0, log_code()}, 32'h0124);
    // R5 R2: read sequence capA(1), RD(8)
    access(0, 16'h0012, 16'h0, 0, 16'hBEEF, "R5");
    chk("R5", "read strobe order", {16'd0, log_code()}, 32'h0018);
    chk("R2", "rdata held", {16'd0, rdata}, 32'hBEEF);

    // more patterns
    access(1, 16'h0000, 16'h0000, 0, 16'h0, "R4");
    access(1, 16'h00FF, 16'hFFFF, 0, 16'h0, "R4");
    access(1, 16'h0055, 16'hA5A5, 0, 16'h0, "R4");
    access(0, 16'h00FF, 16'h0, 0, 16'hFFFF, "R5");
    access(0, 16'h0000, 16'h0, 0, 16'h0000, "R5");
    access(0, 16'h0055, 16'h0, 0, 16'hA5A5, "R2");

    // R6 R10: response after 6 edges is caught on the last check
    dly = 6;
    access(1, 16'h0033, 16'h1234, 0, 16'h0, "R10");
    access(0, 16'h0033, 16'h0, 0, 16'h1234, "R10");
    // 7 edges misses the window
    dly = 7;
    access(1, 16'h0034, 16'h4321, 1, 16'h0, "R6");
    dly = 1;
    repeat (20) @(negedge clk);

    // R6: silent PHY, exact timeout edge
    mute = 1;
    start_access(1, 16'h0040, 16'h7777, 1, 16'h0, "R6");
    wait_done(c);
    chk("R6", "timeout cycles", c, 2 + (LIM - 1) * GAP + 1);
    mute = 0;
    repeat (10) @(negedge clk);

    // R7: ack stuck high aborts
    stuck = 1;
    access(1, 16'h0041, 16'h8888, 1, 16'h0, "R7");
    chk("R7", "only address strobe issued", {16'd0, log_code()}, 32'h0001);
    stuck = 0;
    repeat (20) @(negedge clk);
    access(0, 16'h0055, 16'h0, 0, 16'hA5A5, "R7");

    // R8: request while busy is ignored
    access(1, 16'h0022, 16'h1111, 0, 16'h0, "R8");
    start_access(1, 16'h0021, 16'hAAAA, 0, 16'h0, "R8");
    repeat (3) @(negedge clk);
    chk("R8", "ready low while busy", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0022; req_wdata = 16'h5555;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(c);
    repeat (5) @(negedge clk);
    access(0, 16'h0022, 16'h0, 0, 16'h1111, "R8");
    access(0, 16'h0021, 16'h0, 0, 16'hAAAA, "R8");

    repeat (5) @(negedge clk);
    chk("R9", "all completions seen", exp_q.size(), 32'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule